// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small processor that runs a program held in the same memory as its data. It repeats three phases without end. First it fetches the instruction that the program counter points to into an instruction register. Then it decodes that instruction. Then it executes it using one accumulator, a three-bit condition register and a memory address/data register pair. The processor stops only when it executes Halt.

The memory sits outside the block on a single-port synchronous bus. The bus carries an address, write data, a write enable and read data, and read data returns one clock after the address. The block also has an input word with a valid flag, an output word with a one-cycle strobe, and a halted status line. Every instruction names exactly one memory operand by direct address.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word carries the opcode in bits 15:12 and a direct operand address in bits 11:0. Instructions run in address order, and the program counter advances by one at each fetch.
- R2: Opcode 0 loads memory[X] into the accumulator. Opcode 1 writes the accumulator to memory[X]. Opcode 3 adds memory[X] to the accumulator. Opcode 5 subtracts memory[X] from the accumulator. All results wrap modulo 2^16.
- R3: Opcode 2 writes zero to memory[X]. Opcode 4 writes memory[X]+1 back to memory[X]. Opcode 6 writes memory[X]-1 back to memory[X]. None of these three changes the accumulator.
- R4: Opcode 7 compares memory[X] with the accumulator as signed numbers. It sets exactly one of three condition bits: greater when memory[X] is larger, equal, or less. The condition register never holds more than one set bit.
- R5: Opcode 8 always jumps to X. Opcode 9 jumps on greater, 10 on equal, 11 on less, and 12 when the equal bit is clear. A conditional jump whose condition is false falls through to the next instruction.
- R6: Opcode 13 waits, with no memory write, until in_valid is high. It then stores in_data into memory[X].
- R7: Opcode 14 puts memory[X] on out_data and raises out_stb for exactly one cycle.
- R8: Opcode 15 raises halted. From then until reset there are no memory writes, no strobes and no change of mem_addr, and in_valid is ignored.
- R9: Synchronous reset clears halted, out_stb and mem_we. The first instruction is fetched from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address (from the address register) |
| mem_wdata | output | 16 | Memory write data (from the data register) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after address |
| in_data | input | 16 | Input word |
| in_valid | input | 1 | Input word present |
| out_data | output | 16 | Last output word |
| out_stb | output | 1 | One-cycle pulse when out_data is new |
| halted | output | 1 | Processor has executed Halt |

## Verification
The bench tests signed ordering where unsigned ordering gives the opposite answer: a compare of -1 against 1, and a less-than test against 0xFFFF. A design that compared unsigned would take jumps it should skip. Add, increment and decrement runs cross 0x7FFF/0x8000 and 0xFFFF/0x0000, and each run also stores the accumulator afterwards. An accumulator clobbered by a memory-side operation shows up as a wrong stored value. Further tests hold the input flag low for many cycles, which catches an input instruction that writes too early. Other tests issue two outputs back to back, which catches a strobe that stretches or an output that is lost. A last test keeps stimulus running after Halt, which catches a core that keeps fetching past the stop.

// File: rtl/acp_pkg.sv
package acp_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'd0,
        OP_STORE = 4'd1,
        OP_CLEAR = 4'd2,
        OP_ADD   = 4'd3,
        OP_INC   = 4'd4,
        OP_SUB   = 4'd5,
        OP_DEC   = 4'd6,
        OP_CMP   = 4'd7,
        OP_JMP   = 4'd8,
        OP_JGT   = 4'd9,
        OP_JEQ   = 4'd10,
        OP_JLT   = 4'd11,
        OP_JNE   = 4'd12,
        OP_IN    = 4'd13,
        OP_OUT   = 4'd14,
        OP_HALT  = 4'd15
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_FREAD,
        ST_FLOAD,
        ST_DECODE,
        ST_OREAD,
        ST_OLOAD,
        ST_EXEC,
        ST_WRITE,
        ST_INWAIT,
        ST_HALT
    } phase_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cond_t;

    function automatic logic needs_operand(opcode_e op);
        return op inside {OP_LOAD, OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_CMP, OP_OUT};
    endfunction

    function automatic logic is_jump(opcode_e op);
        return op inside {OP_JMP, OP_JGT, OP_JEQ, OP_JLT, OP_JNE};
    endfunction

    function automatic logic is_rmw(opcode_e op);
        return op inside {OP_INC, OP_DEC};
    endfunction

endpackage

// File: rtl/acp_alu.sv
module acp_alu
    import acp_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_e        op,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   result,
    output cond_t          flags
);
    logic [W-1:0] c_sum, c_diff, c_inc, c_dec;

    // every candidate computed side by side, one picked below
    assign c_sum  = acc + opnd;
    assign c_diff = acc - opnd;
    assign c_inc  = opnd + W'(1);
    assign c_dec  = opnd - W'(1);

    always_comb begin
        unique case (op)
            OP_ADD:  result = c_sum;
            OP_SUB:  result = c_diff;
            OP_INC:  result = c_inc;
            OP_DEC:  result = c_dec;
            default: result = opnd;
        endcase
    end

    always_comb begin
        flags.gt = $signed(opnd) >  $signed(acc);
        flags.eq = opnd == acc;
        flags.lt = $signed(opnd) <  $signed(acc);
    end

endmodule

// File: rtl/acp_branch.sv
module acp_branch
    import acp_pkg::*;
(
    input  opcode_e op,
    input  cond_t   cc,
    output logic    take
);
    always_comb begin
        unique case (op)
            OP_JMP:  take = 1'b1;
            OP_JGT:  take = cc.gt;
            OP_JEQ:  take = cc.eq;
            OP_JLT:  take = cc.lt;
            OP_JNE:  take = !cc.eq;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acp_ctrl.sv
module acp_ctrl
    import acp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    input  logic    in_valid,
    output phase_e  state
);
    phase_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:  nxt = ST_FREAD;
            ST_FREAD:  nxt = ST_FLOAD;
            ST_FLOAD:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (op == OP_HALT)                           nxt = ST_HALT;
                else if (is_jump(op))                        nxt = ST_FETCH;
                else if (op == OP_STORE || op == OP_CLEAR)   nxt = ST_WRITE;
                else if (op == OP_IN)                        nxt = ST_INWAIT;
                else if (needs_operand(op))                  nxt = ST_OREAD;
                else                                         nxt = ST_FETCH;
            end
            ST_OREAD:  nxt = ST_OLOAD;
            ST_OLOAD:  nxt = ST_EXEC;
            ST_EXEC:   nxt = is_rmw(op) ? ST_WRITE : ST_FETCH;
            ST_WRITE:  nxt = ST_FETCH;
            ST_INWAIT: nxt = in_valid ? ST_WRITE : ST_INWAIT;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    // R6: without a valid input the wait phase holds
    a_r6_in_stall: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INWAIT && !in_valid) |=> state == ST_INWAIT);

    // R1: loading the instruction register is always followed by decode
    a_r1_decode_follows: assert property (@(posedge clk) disable iff (rst)
        state == ST_FLOAD |=> state == ST_DECODE);

    // R8: halt is absorbing
    a_r8_halt_absorbs: assert property (@(posedge clk) disable iff (rst)
        state == ST_HALT |=> state == ST_HALT);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [DATA_W-OPC_W-1:0] mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    output logic                   mem_we,
    input  logic [DATA_W-1:0]      mem_rdata,
    input  logic [DATA_W-1:0]      in_data,
    input  logic                   in_valid,
    output logic [DATA_W-1:0]      out_data,
    output logic                   out_stb,
    output logic                   halted
);
    localparam int ADDR_W = DATA_W - OPC_W;

    phase_e              state;
    logic [ADDR_W-1:0]   pc, mar;
    logic [DATA_W-1:0]   ir, acc, mdr;
    cond_t               cc;
    opcode_e             op;
    logic [ADDR_W-1:0]   opaddr;
    logic [DATA_W-1:0]   alu_res;
    cond_t               alu_flags;
    logic                take;

    assign op     = opcode_e'(ir[DATA_W-1 -: OPC_W]);
    assign opaddr = ir[ADDR_W-1:0];

    acp_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .in_valid (in_valid),
        .state    (state)
    );

    acp_alu #(.W(DATA_W)) u_alu (
        .op     (op),
        .acc    (acc),
        .opnd   (mdr),
        .result (alu_res),
        .flags  (alu_flags)
    );

    acp_branch u_branch (
        .op   (op),
        .cc   (cc),
        .take (take)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_we    = state == ST_WRITE;
    assign halted    = state == ST_HALT;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            mar      <= '0;
            ir       <= '0;
            acc      <= '0;
            mdr      <= '0;
            cc       <= '0;
            out_data <= '0;
            out_stb  <= 1'b0;
        end else begin
            out_stb <= 1'b0;
            unique case (state)
                ST_FETCH: begin
                    mar <= pc;
                    pc  <= pc + ADDR_W'(1);
                end
                ST_FLOAD: ir <= mem_rdata;
                ST_DECODE: begin
                    mar <= opaddr;
                    if (take)           pc  <= opaddr;
                    if (op == OP_STORE) mdr <= acc;
                    if (op == OP_CLEAR) mdr <= '0;
                end
                ST_OLOAD: mdr <= mem_rdata;
                ST_EXEC: begin
                    unique case (op)
                        OP_LOAD, OP_ADD, OP_SUB: acc <= alu_res;
                        OP_INC, OP_DEC:          mdr <= alu_res;
                        OP_CMP:                  cc  <= alu_flags;
                        OP_OUT: begin
                            out_data <= mdr;
                            out_stb  <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_INWAIT: if (in_valid) mdr <= in_data;
                default: ;
            endcase
        end
    end

    // R1: each fetch steps the program counter by one
    a_r1_pc_step: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> pc == $past(pc) + ADDR_W'(1));

    // R5: an untaken jump leaves the program counter alone
    a_r5_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && is_jump(op) && !take) |=> pc == $past(pc));

    // R4: the condition register never holds two bits
    a_r4_cc_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cc));

    // R4: a compare leaves exactly one bit set
    a_r4_cmp_sets_one: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && op == OP_CMP) |=> $countones(cc) == 1);

    // R3: memory-side arithmetic leaves the accumulator intact
    a_r3_acc_kept: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && is_rmw(op)) |=> $stable(acc));

    // R2: a store writes the accumulator value
    a_r2_store_data: assert property (@(posedge clk) disable iff (rst)
        (mem_we && op == OP_STORE) |-> mem_wdata == acc);

    // R7: the output strobe lasts one cycle
    a_r7_stb_single: assert property (@(posedge clk) disable iff (rst)
        out_stb |=> !out_stb);

    // R8: once halted, the bus is quiet and frozen
    a_r8_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && !mem_we && !out_stb && $stable(mem_addr));

endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic [15:0] out_data;
    logic        out_stb;
    logic        halted;

    int n_chk = 0;
    int n_fail = 0;
    int n_writes = 0;
    int n_stb = 0;
    logic [15:0] stb_val [0:3];

    logic [15:0] mem [0:4095];

    always #5 clk = ~clk;

    acc_cpu u0 (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata),
        .in_data(in_data), .in_valid(in_valid),
        .out_data(out_data), .out_stb(out_stb), .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_we === 1'b1) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (!rst && mem_we === 1'b1) n_writes++;
        if (!rst && out_stb === 1'b1) begin
            if (n_stb < 4) stb_val[n_stb] = out_data;
            n_stb++;
        end
    end

    // each entry: opcode, accumulator value a, operand b, expected result
    localparam logic [51:0] VEC [0:20] = '{
        {4'd0,  16'h1234, 16'hBEEF, 16'hBEEF},
        {4'd1,  16'h0042, 16'h9999, 16'h0042},
        {4'd3,  16'h0003, 16'h0004, 16'h0007},
        {4'd3,  16'h7FFF, 16'h0001, 16'h8000},
        {4'd3,  16'hFFFF, 16'h0001, 16'h0000},
        {4'd5,  16'h000A, 16'h0003, 16'h0007},
        {4'd5,  16'h0003, 16'h000A, 16'hFFF9},
        {4'd2,  16'h0011, 16'h5A5A, 16'h0000},
        {4'd4,  16'h0022, 16'h00FF, 16'h0100},
        {4'd4,  16'h0033, 16'hFFFF, 16'h0000},
        {4'd6,  16'h0044, 16'h0000, 16'hFFFF},
        {4'd9,  16'h0001, 16'h0002, 16'h0006},
        {4'd9,  16'h0002, 16'h0002, 16'h0000},
        {4'd9,  16'h0001, 16'hFFFF, 16'h0000},
        {4'd10, 16'h0005, 16'h0005, 16'h0006},
        {4'd10, 16'h0005, 16'h0006, 16'h0000},
        {4'd11, 16'h0001, 16'hFFFF, 16'h0006},
        {4'd11, 16'h0003, 16'h0004, 16'h0000},
        {4'd12, 16'h0003, 16'h0004, 16'h0006},
        {4'd12, 16'h0007, 16'h0007, 16'h0000},
        {4'd8,  16'h0000, 16'h0000, 16'h0006}
    };

    function automatic logic [15:0] ins(input int op, input int adr);
        return {4'(op), 12'(adr)};
    endfunction

    function automatic string tag_of(input int op);
        if (op == 0 || op == 1 || op == 3 || op == 5) return "R2";
        if (op == 2 || op == 4 || op == 6) return "R3";
        return "R5/R4";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic wipe();
        for (int k = 0; k < 4096; k++) mem[k] = 16'h0;
    endtask

    task automatic start();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        n_writes = 0;
        n_stb = 0;
        rst = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        int k;
        k = 0;
        while (halted !== 1'b1 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(tag, "reached halt", 32'(halted === 1'b1), 32'd1);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] frozen_addr;

        // R9: reset state and first fetch address
        wipe();
        mem[0] = ins(15, 0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "halted in reset", 32'(halted), 32'd0);
        check("R9", "out_stb in reset", 32'(out_stb), 32'd0);
        check("R9", "mem_we in reset", 32'(mem_we), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9", "first fetch address", 32'(mem_addr), 32'd0);
        wait_halt("R9");

        // table of single-operation programs
        for (int i = 0; i < 21; i++) begin
            int op;
            logic [15:0] a, b, e;
            op = int'(VEC[i][51:48]);
            a = VEC[i][47:32];
            b = VEC[i][31:16];
            e = VEC[i][15:0];
            wipe();
            mem[12'h100] = a;
            mem[12'h101] = b;
            mem[12'h102] = 16'h0005;
            mem[0] = ins(0, 12'h100);
            if (op >= 8) begin
                mem[1] = ins(7, 12'h101);
                mem[2] = ins(op, 5);
                mem[3] = ins(2, 12'h102);
                mem[4] = ins(15, 0);
                mem[5] = ins(4, 12'h102);
                mem[6] = ins(15, 0);
            end else begin
                mem[1] = ins(op, 12'h101);
                mem[2] = ins(1, 12'h102);
                mem[3] = ins(15, 0);
            end
            start();
            wait_halt("R1");
            if (op >= 8) begin
                check(tag_of(op), $sformatf("jump op %0d path marker", op),
                      32'(mem[12'h102]), 32'(e));
            end else if (op == 0 || op == 3 || op == 5) begin
                check(tag_of(op), $sformatf("acc op %0d result", op),
                      32'(mem[12'h102]), 32'(e));
            end else begin
                check(tag_of(op), $sformatf("mem op %0d cell", op),
                      32'(mem[12'h101]), 32'(e));
                check(tag_of(op), $sformatf("op %0d acc after", op),
                      32'(mem[12'h102]), 32'(a));
            end
        end

        // R1: straight-line sequence with mixed opcodes
        wipe();
        for (int k = 0; k < 4; k++) mem[k] = ins(4, 12'h200);
        mem[4] = ins(0, 12'h200);
        mem[5] = ins(3, 12'h200);
        mem[6] = ins(1, 12'h201);
        mem[7] = ins(15, 0);
        start();
        wait_halt("R1");
        check("R1", "four increments", 32'(mem[12'h200]), 32'd4);
        check("R1", "load then add", 32'(mem[12'h201]), 32'd8);

        // R6: input stalls until valid
        wipe();
        mem[0] = ins(13, 12'h300);
        mem[1] = ins(0, 12'h300);
        mem[2] = ins(3, 12'h300);
        mem[3] = ins(1, 12'h301);
        mem[4] = ins(15, 0);
        in_data = 16'h1111;
        start();
        repeat (60) @(negedge clk);
        check("R6", "no write while waiting", 32'(n_writes), 32'd0);
        check("R6", "not halted while waiting", 32'(halted), 32'd0);
        in_valid = 1'b1;
        while (mem_we !== 1'b1) @(negedge clk);
        in_valid = 1'b0;
        wait_halt("R6");
        check("R6", "stored input", 32'(mem[12'h300]), 32'h1111);
        check("R6", "doubled input", 32'(mem[12'h301]), 32'h2222);

        // R7: two outputs in a row
        wipe();
        mem[12'h310] = 16'hCAFE;
        mem[12'h311] = 16'h0123;
        mem[0] = ins(14, 12'h310);
        mem[1] = ins(14, 12'h311);
        mem[2] = ins(15, 0);
        start();
        wait_halt("R7");
        check("R7", "strobe count", 32'(n_stb), 32'd2);
        check("R7", "first output", 32'(stb_val[0]), 32'hCAFE);
        check("R7", "second output", 32'(stb_val[1]), 32'h0123);
        check("R7", "no write on output", 32'(n_writes), 32'd0);

        // R8: frozen after halt, with inputs wiggling
        wipe();
        mem[0] = ins(15, 0);
        mem[1] = ins(4, 12'h320);
        mem[2] = ins(13, 12'h321);
        start();
        wait_halt("R8");
        frozen_addr = 16'(mem_addr);
        in_valid = 1'b1;
        in_data  = 16'h7777;
        repeat (30) @(negedge clk);
        check("R8", "still halted", 32'(halted), 32'd1);
        check("R8", "address frozen", 32'(mem_addr), 32'(frozen_addr));
        check("R8", "no writes after halt", 32'(n_writes), 32'd0);
        check("R8", "no strobes after halt", 32'(n_stb), 32'd0);
        check("R8", "next instruction not run", 32'(mem[12'h320]), 32'd0);
        check("R8", "input ignored", 32'(mem[12'h321]), 32'd0);
        in_valid = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule